// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

A 32-pin general-purpose I/O port reached through a plain 32-bit register bus. Software sets the level each output pin drives, chooses which pins are outputs, and reads back the synchronized level of every pad. Each pin also feeds a small detector. The detector watches for a selectable low level, high level, rising edge or falling edge and latches a sticky status bit. Status bits are cleared by writing ones. They are gated by a mask register and collected into one interrupt output for the lower sixteen pins, one for the upper sixteen, and a combined output.

Register access is strobe based. A write takes effect on the clock edge where `bus_wr` is high. A read strobe on `bus_rd` loads `bus_rdata` on that edge, so the data is valid one cycle later. Pad inputs pass through a two-stage synchronizer before anything else uses them. A change on a pin therefore reaches the status register on the third rising clock edge after it arrives.

Top module: `gpio_irq_port`

## Requirements
- R1: Registers sit at byte offsets 0x00 output data, 0x04 direction, 0x08 pad level (read-only), 0x0C condition select low, 0x10 condition select high, 0x14 mask, 0x18 status. Data, direction, both condition selects and the mask reset to 0. `bus_rdata` holds the addressed register from the edge that samples `bus_rd` onward.
- R2: `pin_out` always equals the data register. `pin_oe[n]` equals direction bit n, where 1 means the pin is driven.
- R3: The pad-level register returns `pin_in` after two clock stages, whatever the direction bits are. Writes to it are ignored.
- R4: Pins 0–15 take their condition from the low select register and pins 16–31 from the high one. Pin n uses bits [2*(n mod 16)+1 : 2*(n mod 16)].
- R5: Condition code 0 detects a low level, 1 a high level, 2 a rising edge and 3 a falling edge. A status bit is set only by a detected condition. A pin change that arrives before clock edge k sets the status bit at edge k+2.
- R6: While a level condition holds, its status bit is set again on every cycle, so a clear written during the level does not last.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R8: A detection and a clear of the same bit on the same edge leave the bit set.
- R9: An interrupt output is asserted only for pins whose status and mask bits are both 1. The mask resets to 0, so no interrupt is raised after reset.
- R10: `irq_lo` is the OR of masked status over pins 0–15, `irq_hi` the OR over pins 16–31, and `irq_any` is the OR of the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | 32 | Pad input levels (asynchronous) |
| pin_out | output | 32 | Levels to drive on output pins |
| pin_oe | output | 32 | Output enable per pin |
| irq_lo | output | 1 | Interrupt for pins 0–15 |
| irq_hi | output | 1 | Interrupt for pins 16–31 |
| irq_any | output | 1 | OR of both interrupt outputs |

## Verification
Several properties are checked on every cycle against the internal detect and status signals. A status bit never rises without a detection on the previous edge. A written one always clears unless a detection coincides with it, and a coinciding detection always wins. An interrupt output implies a pending masked status bit, and the output enables follow a direction write. Only the bench scenarios can show the rest. This covers the meaning of each condition code on a real pin waveform, the three-edge latency through the synchronizer, and the mapping of pins onto the two select registers. It also covers a level condition overriding a clear, and the split of interrupts between the two half-ports.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int unsigned REG_W  = 32;
   localparam int unsigned ADDR_W = 5;

   localparam logic [ADDR_W-1:0] OFS_DATA = 5'h00;
   localparam logic [ADDR_W-1:0] OFS_DIR  = 5'h04;
   localparam logic [ADDR_W-1:0] OFS_PAD  = 5'h08;
   localparam logic [ADDR_W-1:0] OFS_SELL = 5'h0C;
   localparam logic [ADDR_W-1:0] OFS_SELH = 5'h10;
   localparam logic [ADDR_W-1:0] OFS_MASK = 5'h14;
   localparam logic [ADDR_W-1:0] OFS_STAT = 5'h18;

   typedef enum logic [1:0] {
      COND_LOW  = 2'd0,
      COND_HIGH = 2'd1,
      COND_RISE = 2'd2,
      COND_FALL = 2'd3
   } cond_e;

   function automatic logic cond_hit(input logic [1:0] code, input logic cur, input logic prv);
      case (cond_e'(code))
         COND_LOW:  return !cur;
         COND_HIGH: return cur;
         COND_RISE: return cur & !prv;
         default:   return !cur & prv;
      endcase
   endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int unsigned NPIN   = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] pin_i,
   output logic [NPIN-1:0] sync_o
);
   logic [STAGES-1:0][NPIN-1:0] stg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= {stg_q[STAGES-2:0], pin_i};
   end

   assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NPIN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] sync_i,
   input  logic [NPIN-1:0] sel_lo_i,
   input  logic [NPIN-1:0] sel_hi_i,
   output logic [NPIN-1:0] evt_o
);
   localparam int unsigned HALF = NPIN / 2;

   logic [NPIN-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sync_i;
   end

   for (genvar p = 0; p < NPIN; p++) begin : g_pin
      localparam int unsigned FLD = 2 * (p % HALF);
      logic [1:0] code;
      if (p < HALF) begin : g_lo
         assign code = sel_lo_i[FLD +: 2];
      end else begin : g_hi
         assign code = sel_hi_i[FLD +: 2];
      end
      assign evt_o[p] = cond_hit(code, sync_i[p], prev_q[p]);
   end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NPIN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   input  logic [NPIN-1:0]   pad_i,
   input  logic [NPIN-1:0]   evt_i,
   output logic [NPIN-1:0]   data_o,
   output logic [NPIN-1:0]   dir_o,
   output logic [NPIN-1:0]   sel_lo_o,
   output logic [NPIN-1:0]   sel_hi_o,
   output logic [NPIN-1:0]   mask_o,
   output logic [NPIN-1:0]   stat_o,
   output logic [REG_W-1:0]  rdata_o
);
   logic [NPIN-1:0]  clr;
   logic [REG_W-1:0] rd_mux;

   assign clr = (bus_wr && bus_addr == OFS_STAT) ? bus_wdata : '0;

   always_comb begin
      case (bus_addr)
         OFS_DATA: rd_mux = data_o;
         OFS_DIR:  rd_mux = dir_o;
         OFS_PAD:  rd_mux = pad_i;
         OFS_SELL: rd_mux = sel_lo_o;
         OFS_SELH: rd_mux = sel_hi_o;
         OFS_MASK: rd_mux = mask_o;
         OFS_STAT: rd_mux = stat_o;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_o   <= '0;
         dir_o    <= '0;
         sel_lo_o <= '0;
         sel_hi_o <= '0;
         mask_o   <= '0;
         stat_o   <= '0;
         rdata_o  <= '0;
      end else begin
         if (bus_wr) begin
            case (bus_addr)
               OFS_DATA: data_o   <= bus_wdata;
               OFS_DIR:  dir_o    <= bus_wdata;
               OFS_SELL: sel_lo_o <= bus_wdata;
               OFS_SELH: sel_hi_o <= bus_wdata;
               OFS_MASK: mask_o   <= bus_wdata;
               default: ;
            endcase
         end
         stat_o <= (stat_o & ~clr) | evt_i;
         if (bus_rd) rdata_o <= rd_mux;
      end
   end
endmodule

// File: rtl/gpio_irq_out.sv
module gpio_irq_out #(
   parameter int unsigned NPIN  = 32,
   parameter int unsigned NHALF = 2
) (
   input  logic [NPIN-1:0]  stat_i,
   input  logic [NPIN-1:0]  mask_i,
   output logic [NHALF-1:0] irq_o,
   output logic             irq_any_o
);
   localparam int unsigned SEG = NPIN / NHALF;

   for (genvar h = 0; h < NHALF; h++) begin : g_seg
      assign irq_o[h] = |(stat_i[h*SEG +: SEG] & mask_i[h*SEG +: SEG]);
   end

   assign irq_any_o = |irq_o;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NPIN        = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [REG_W-1:0]     bus_wdata,
   output logic [REG_W-1:0]     bus_rdata,
   input  logic [NPIN-1:0]      pin_in,
   output logic [NPIN-1:0]      pin_out,
   output logic [NPIN-1:0]      pin_oe,
   output logic                 irq_lo,
   output logic                 irq_hi,
   output logic                 irq_any
);
   localparam int unsigned NHALF = 2;

   if (NPIN != REG_W) begin : g_bad_npin
      $error("gpio_irq_port: NPIN must equal the 32-bit register width");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_irq_port: SYNC_STAGES must be at least 2");
   end

   logic [NPIN-1:0]  pad_w, evt_w, sel_lo_w, sel_hi_w, mask_q, stat_q;
   logic [NHALF-1:0] irq_w;

   gpio_irq_sync #(.NPIN(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_in), .sync_o(pad_w)
   );

   gpio_irq_detect #(.NPIN(NPIN)) u_det (
      .clk(clk), .rst_n(rst_n), .sync_i(pad_w),
      .sel_lo_i(sel_lo_w), .sel_hi_i(sel_hi_w), .evt_o(evt_w)
   );

   gpio_irq_regs #(.NPIN(NPIN)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pad_i(pad_w), .evt_i(evt_w),
      .data_o(pin_out), .dir_o(pin_oe), .sel_lo_o(sel_lo_w), .sel_hi_o(sel_hi_w),
      .mask_o(mask_q), .stat_o(stat_q), .rdata_o(bus_rdata)
   );

   gpio_irq_out #(.NPIN(NPIN), .NHALF(NHALF)) u_out (
      .stat_i(stat_q), .mask_i(mask_q), .irq_o(irq_w), .irq_any_o(irq_any)
   );

   assign irq_lo = irq_w[0];
   assign irq_hi = irq_w[1];
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NPIN = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [REG_W-1:0]  bus_wdata,
   input logic [NPIN-1:0]   pin_oe,
   input logic              irq_any,
   input logic [NPIN-1:0]   evt,
   input logic [NPIN-1:0]   stat,
   input logic [NPIN-1:0]   mask
);
   // R5
   stat_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((stat & ~$past(stat) & ~$past(evt)) == '0));

   // R7
   stat_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(bus_wr) && $past(bus_addr) == OFS_STAT)
      |-> ((stat & $past(bus_wdata) & ~$past(evt)) == '0));

   // R8
   stat_evt_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (($past(evt) & ~stat) == '0));

   // R9
   irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_any |-> ((stat & mask) != '0));

   // R2
   dir_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(bus_wr) && $past(bus_addr) == OFS_DIR)
      |-> (pin_oe == $past(bus_wdata)));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPIN(NPIN)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .pin_oe(pin_oe), .irq_any(irq_any),
   .evt(evt_w), .stat(stat_q), .mask(mask_q)
);

// File: tb/gpio_irq_port_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_port_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
   logic        irq_lo, irq_hi, irq_any;
   int          checks = 0, fails = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   gpio_irq_port dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_any(irq_any)
   );

   // vector: {code[1:0], start level, end level, expected status of pin 3}
   localparam logic [4:0] VEC [0:8] = '{
      {2'd0, 1'b1, 1'b1, 1'b0}, {2'd0, 1'b1, 1'b0, 1'b1},
      {2'd1, 1'b0, 1'b0, 1'b0}, {2'd1, 1'b0, 1'b1, 1'b1},
      {2'd2, 1'b0, 1'b1, 1'b1}, {2'd2, 1'b1, 1'b0, 1'b0},
      {2'd2, 1'b1, 1'b1, 1'b0}, {2'd3, 1'b1, 1'b0, 1'b1},
      {2'd3, 1'b0, 1'b1, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      rd(5'h00, r); chk("R1 data reset", r, 32'h0);
      rd(5'h04, r); chk("R1 dir reset", r, 32'h0);
      rd(5'h0C, r); chk("R1 sel_lo reset", r, 32'h0);
      rd(5'h14, r); chk("R1 mask reset", r, 32'h0);
      // R9 no interrupt with reset mask even though low-level status is pending
      rd(5'h18, r); chk("R9 status pending after reset", r, 32'hFFFF_FFFF);
      chk("R9 irq_any low after reset", {31'b0, irq_any}, 32'h0);

      // R2 data and direction
      wr(5'h00, 32'hA5A5_0F0F);
      wr(5'h04, 32'h0000_FFFF);
      chk("R2 pin_out", pin_out, 32'hA5A5_0F0F);
      chk("R2 pin_oe", pin_oe, 32'h0000_FFFF);
      rd(5'h00, r); chk("R1 data readback", r, 32'hA5A5_0F0F);

      // R3 pad level independent of direction, read-only
      pin_in = 32'h1234_8765;
      idle(3);
      rd(5'h08, r); chk("R3 pad level", r, 32'h1234_8765);
      wr(5'h08, 32'h0);
      rd(5'h08, r); chk("R3 pad write ignored", r, 32'h1234_8765);
      pin_in = 32'h0;

      // R4 R5 vector table on pin 3 (field bits [7:6] of low select)
      for (int v = 0; v < 9; v++) begin
         wr(5'h0C, {16{VEC[v][4:3]}});
         pin_in[3] = VEC[v][2];
         idle(4);
         wr(5'h18, 32'hFFFF_FFFF);
         idle(1);
         pin_in[3] = VEC[v][1];
         idle(4);
         rd(5'h18, r);
         chk($sformatf("R5 vector %0d", v), {31'b0, r[3]}, {31'b0, VEC[v][0]});
      end

      // R5 latency: rising edge on pin 3 sets status at the third edge
      wr(5'h0C, {16{2'd2}});
      pin_in[3] = 1'b0;
      idle(4);
      wr(5'h18, 32'hFFFF_FFFF);
      wr(5'h14, 32'h0000_0008);
      pin_in[3] = 1'b1;
      idle(2);
      chk("R5 not yet after two edges", {31'b0, irq_lo}, 32'h0);
      idle(1);
      chk("R5 set after three edges", {31'b0, irq_lo}, 32'h1);
      chk("R10 irq_hi stays low", {31'b0, irq_hi}, 32'h0);

      // R7 writing zero keeps, writing one clears
      wr(5'h18, 32'h0);
      chk("R7 write zero keeps", {31'b0, irq_lo}, 32'h1);
      wr(5'h18, 32'h0000_0008);
      chk("R7 write one clears", {31'b0, irq_lo}, 32'h0);

      // R4 R10 pin 20 uses high select bits [9:8]
      wr(5'h10, 32'h0000_0200);
      pin_in[20] = 1'b0;
      idle(4);
      wr(5'h18, 32'hFFFF_FFFF);
      wr(5'h14, 32'h0010_0000);
      pin_in[20] = 1'b1;
      idle(3);
      chk("R10 irq_hi for pin 20", {29'b0, irq_hi, irq_lo, irq_any}, 32'h5);
      rd(5'h18, r); chk("R4 pin 20 status only", r & 32'h0010_0008, 32'h0010_0000);
      wr(5'h18, 32'h0010_0000);

      // R9 status set but masked out
      wr(5'h14, 32'h0);
      pin_in[20] = 1'b0;
      idle(4);
      pin_in[20] = 1'b1;
      idle(3);
      rd(5'h18, r); chk("R9 status set while masked", r & 32'h0010_0000, 32'h0010_0000);
      chk("R9 irq_hi masked", {31'b0, irq_hi}, 32'h0);

      // R6 high level on pin 5 (low select bits [11:10]) survives a clear
      wr(5'h0C, 32'h0000_0400);
      wr(5'h14, 32'h0000_0020);
      pin_in[5] = 1'b1;
      idle(4);
      wr(5'h18, 32'h0000_0020);
      rd(5'h18, r); chk("R6 level re-sets status", r & 32'h20, 32'h20);
      chk("R6 irq_lo held", {31'b0, irq_lo}, 32'h1);
      pin_in[5] = 1'b0;
      idle(4);
      wr(5'h18, 32'h0000_0020);
      chk("R6 cleared once level gone", {31'b0, irq_lo}, 32'h0);

      // R8 rising edge on pin 3 coinciding with its clear
      wr(5'h0C, {16{2'd2}});
      wr(5'h14, 32'h0000_0008);
      pin_in[3] = 1'b0;
      idle(4);
      wr(5'h18, 32'hFFFF_FFFF);
      pin_in[3] = 1'b1;
      idle(2);
      wr(5'h18, 32'h0000_0008);
      chk("R8 event wins over clear", {31'b0, irq_lo}, 32'h1);

      done = 1'b1;
      finish_run();
   end
endmodule